// File: doc/BRIEF.md
# Cache Slot Lock Stack

This block tracks which instruction-cache slots are pinned against replacement. The pins are handed out as a stack that grows downward. A 6-bit slot pointer names the slot that the next pin will use. Each slot has one lock flag.

A pin is taken when a table-read access happens while push mode is on. The slot the pointer names is locked, and the pointer then moves down by one. A pop request moves the pointer up by one and then releases the slot it now names.

The block drives the effective lock state of every slot and a single-slot protection query, which the replacement engine uses to skip pinned slots. It also exposes the pointer, the push-mode bit and the pop bit for read-back. While the pointer is zero, every slot reads as unlocked, whatever the flags hold.

Top module: `slot_lock_stack`

## Requirements
- R1: After reset, `slot_ptr_o` is 62 (binary 111110), every bit of `lock_mask_o` is 0 and `push_en_o` is 0.
- R2: A cycle with `table_rd_i` high while `push_en_o` is 1 sets the lock flag of the slot that `slot_ptr_o` names. At the next edge, `slot_ptr_o` becomes its old value minus 1.
- R3: A cycle with `table_rd_i` high while `push_en_o` is 0 leaves `slot_ptr_o` and `lock_mask_o` unchanged.
- R4: A `pop_i` cycle with `slot_ptr_o` not equal to 62 and no push raises `slot_ptr_o` by 1. It then clears the lock flag of the slot the new pointer value names.
- R5: A `pop_i` cycle while `slot_ptr_o` is 62 is ignored: pointer and `lock_mask_o` stay unchanged.
- R6: When a push and `pop_i` occur in the same cycle, only the push takes effect.
- R7: While `slot_ptr_o` is 0, `lock_mask_o` is all zeros and `query_locked_o` is 0, regardless of the stored flags.
- R8: `query_locked_o` equals bit `query_slot_i` of `lock_mask_o` in the same cycle. Bit i of `lock_mask_o` is the lock state of slot i.
- R9: The pop control bit always reads back as 0 (`pop_rd_o` = 0).
- R10: A cycle with `push_en_we_i` high loads `push_en_d_i` into `push_en_o` at that edge. A push in that same cycle uses the old `push_en_o` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_en_we_i | input | 1 | Write strobe for the push-mode bit |
| push_en_d_i | input | 1 | New push-mode value |
| table_rd_i | input | 1 | Table-read access this cycle |
| pop_i | input | 1 | Pop request (pop bit written with 1) |
| query_slot_i | input | 6 | Slot index for the protection query |
| query_locked_o | output | 1 | Queried slot is protected |
| lock_mask_o | output | 64 | Effective lock state per slot |
| slot_ptr_o | output | 6 | Slot pointer read-back |
| push_en_o | output | 1 | Push-mode bit read-back |
| pop_rd_o | output | 1 | Pop bit read-back, always 0 |

## Verification
A wrong pointer step shows up on `slot_ptr_o` at the edge after the request. It then spreads into `lock_mask_o` on the next push or pop, because the wrong slot is marked or released.

A flag that is set or cleared wrongly shows up at once as a single wrong bit of `lock_mask_o`. A full query sweep exposes the same fault through `query_locked_o`.

A broken zero-pointer override is seen only when the stack is driven all the way down. For that reason the sweeps fill the stack to its limit, empty it again, and fill it down to zero.

// File: rtl/slk_pkg.sv
package slk_pkg;
  parameter int unsigned SLK_PTR_W = 6;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } slk_op_e;
endpackage

// File: rtl/slk_ptr.sv
module slk_ptr
  import slk_pkg::*;
#(
  parameter int unsigned PTR_W = SLK_PTR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_en_we_i,
  input  logic             push_en_d_i,
  input  logic             table_rd_i,
  input  logic             pop_i,
  output slk_op_e          op_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             push_en_o
);
  localparam logic [PTR_W-1:0] PTR_TOP = {{(PTR_W-1){1'b1}}, 1'b0};

  logic [PTR_W-1:0] ptr_q;
  logic             push_en_q;
  slk_op_e          op;

  always_comb begin
    op = OP_IDLE;
    if (table_rd_i && push_en_q)    op = OP_PUSH;   // push wins over pop
    else if (pop_i && ptr_q != PTR_TOP) op = OP_POP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= PTR_TOP;
      push_en_q <= 1'b0;
    end else begin
      if (push_en_we_i) push_en_q <= push_en_d_i;
      unique case (op)
        OP_PUSH: ptr_q <= ptr_q - 1'b1;
        OP_POP:  ptr_q <= ptr_q + 1'b1;
        default: ptr_q <= ptr_q;
      endcase
    end
  end

  assign op_o      = op;
  assign ptr_o     = ptr_q;
  assign push_en_o = push_en_q;
endmodule

// File: rtl/slk_flags.sv
module slk_flags
  import slk_pkg::*;
#(
  parameter int unsigned PTR_W = SLK_PTR_W,
  localparam int unsigned NUM_SLOTS = 1 << PTR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  slk_op_e              op_i,
  input  logic [PTR_W-1:0]     ptr_i,
  output logic [NUM_SLOTS-1:0] flags_o
);
  logic [PTR_W-1:0] ptr_up;
  assign ptr_up = ptr_i + 1'b1;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        flag_q <= 1'b0;
      else if (op_i == OP_PUSH && ptr_i == PTR_W'(g))
        flag_q <= 1'b1;
      else if (op_i == OP_POP && ptr_up == PTR_W'(g))
        flag_q <= 1'b0;
    end
    assign flags_o[g] = flag_q;
  end
endmodule

// File: rtl/slk_query.sv
module slk_query #(
  parameter int unsigned PTR_W = slk_pkg::SLK_PTR_W,
  localparam int unsigned NUM_SLOTS = 1 << PTR_W
) (
  input  logic [NUM_SLOTS-1:0] flags_i,
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [PTR_W-1:0]     slot_i,
  output logic [NUM_SLOTS-1:0] mask_o,
  output logic                 locked_o
);
  // zero pointer releases everything
  assign mask_o   = (ptr_i == '0) ? '0 : flags_i;
  assign locked_o = mask_o[slot_i];
endmodule

// File: rtl/slot_lock_stack.sv
module slot_lock_stack
  import slk_pkg::*;
#(
  parameter int unsigned PTR_W = SLK_PTR_W,
  localparam int unsigned NUM_SLOTS = 1 << PTR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 push_en_we_i,
  input  logic                 push_en_d_i,
  input  logic                 table_rd_i,
  input  logic                 pop_i,
  input  logic [PTR_W-1:0]     query_slot_i,
  output logic                 query_locked_o,
  output logic [NUM_SLOTS-1:0] lock_mask_o,
  output logic [PTR_W-1:0]     slot_ptr_o,
  output logic                 push_en_o,
  output logic                 pop_rd_o
);
  slk_op_e              op;
  logic [PTR_W-1:0]     ptr;
  logic [NUM_SLOTS-1:0] flags;

  slk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_en_we_i (push_en_we_i),
    .push_en_d_i  (push_en_d_i),
    .table_rd_i   (table_rd_i),
    .pop_i        (pop_i),
    .op_o         (op),
    .ptr_o        (ptr),
    .push_en_o    (push_en_o)
  );

  slk_flags #(.PTR_W(PTR_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .ptr_i   (ptr),
    .flags_o (flags)
  );

  slk_query #(.PTR_W(PTR_W)) u_query (
    .flags_i  (flags),
    .ptr_i    (ptr),
    .slot_i   (query_slot_i),
    .mask_o   (lock_mask_o),
    .locked_o (query_locked_o)
  );

  assign slot_ptr_o = ptr;
  assign pop_rd_o   = 1'b0;
endmodule

// File: rtl/slk_checker.sv
module slk_checker #(
  parameter int unsigned PTR_W = 6,
  localparam int unsigned NUM_SLOTS = 1 << PTR_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 table_rd_i,
  input logic                 pop_i,
  input logic [PTR_W-1:0]     query_slot_i,
  input logic                 query_locked_o,
  input logic [NUM_SLOTS-1:0] lock_mask_o,
  input logic [PTR_W-1:0]     slot_ptr_o,
  input logic                 push_en_o
);
  localparam logic [PTR_W-1:0] TOP = {{(PTR_W-1){1'b1}}, 1'b0};
  logic push_ev;
  assign push_ev = table_rd_i && push_en_o;

  assert_push_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_ev |=> slot_ptr_o == PTR_W'($past(slot_ptr_o) - 1'b1));

  assert_push_lock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ev && slot_ptr_o > PTR_W'(1)) |=> lock_mask_o[slot_ptr_o + 1'b1]);

  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_ev && !pop_i) |=> $stable(slot_ptr_o) && $stable(lock_mask_o));

  assert_pop_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_ev && slot_ptr_o != TOP) |=>
      slot_ptr_o == PTR_W'($past(slot_ptr_o) + 1'b1) && !lock_mask_o[slot_ptr_o]);

  assert_pop_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_ev && slot_ptr_o == TOP) |=> $stable(slot_ptr_o) && $stable(lock_mask_o));

  assert_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_ptr_o == '0 |-> lock_mask_o == '0 && !query_locked_o);

  assert_query_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    query_locked_o == lock_mask_o[query_slot_i]);
endmodule

bind slot_lock_stack slk_checker #(.PTR_W(PTR_W)) u_slk_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .table_rd_i     (table_rd_i),
  .pop_i          (pop_i),
  .query_slot_i   (query_slot_i),
  .query_locked_o (query_locked_o),
  .lock_mask_o    (lock_mask_o),
  .slot_ptr_o     (slot_ptr_o),
  .push_en_o      (push_en_o)
);

// File: tb/sim_slot_lock_stack.sv
`timescale 1ns/1ps
module sim_slot_lock_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pe_we = 1'b0, pe_d = 1'b0, trd = 1'b0, pop = 1'b0;
  logic [5:0]  qs = '0;
  logic        qlk;
  logic [63:0] mask;
  logic [5:0]  ptr;
  logic        pe_o, pop_rd;

  int checks = 0, fails = 0;
  int mp = 62;
  logic [63:0] mflags = '0;
  logic mpe = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  slot_lock_stack u0 (
    .clk_i(clk), .rst_ni(rst_n), .push_en_we_i(pe_we), .push_en_d_i(pe_d),
    .table_rd_i(trd), .pop_i(pop), .query_slot_i(qs), .query_locked_o(qlk),
    .lock_mask_o(mask), .slot_ptr_o(ptr), .push_en_o(pe_o), .pop_rd_o(pop_rd)
  );

  function automatic logic [63:0] exp_mask();
    return (mp == 0) ? 64'd0 : mflags;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " ptr"}, 64'(ptr), 64'(mp));
    chk({req, " mask"}, mask, exp_mask());
  endtask

  // one clock with given requests; model updated from the requirements
  task automatic cycle(input logic rd, input logic pp, input logic we, input logic d);
    trd = rd; pop = pp; pe_we = we; pe_d = d;
    @(negedge clk);
    if (rd && mpe) begin
      mflags[mp] = 1'b1;
      mp = (mp + 63) % 64;
    end else if (pp && mp != 62) begin
      mp = mp + 1;
      mflags[mp] = 1'b0;
    end
    if (we) mpe = d;
    trd = 0; pop = 0; pe_we = 0; pe_d = 0;
  endtask

  task automatic query_sweep(input string req);
    for (int s = 0; s < 64; s++) begin
      qs = 6'(s);
      #1;
      chk(req, 64'(qlk), 64'(exp_mask() >> s) & 64'd1);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk_state("R1");
    chk("R1 push_en", 64'(pe_o), 64'd0);
    chk("R9 pop_rd", 64'(pop_rd), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 table reads without push mode
    for (int i = 0; i < 3; i++) begin
      cycle(1, 0, 0, 0);
      chk_state("R3");
    end

    // R10 write push enable together with a read: old value used
    cycle(1, 0, 1, 1);
    chk("R10 push_en", 64'(pe_o), 64'd1);
    chk_state("R10");

    // R2 fill 61 slots; R6 collision at step 30
    for (int i = 0; i < 61; i++) begin
      cycle(1, (i == 30), 0, 0);
      chk_state(i == 30 ? "R6" : "R2");
    end
    query_sweep("R8");
    chk("R9 pop_rd", 64'(pop_rd), 64'd0);

    // R4 empty the stack
    for (int i = 0; i < 61; i++) begin
      cycle(0, 1, 0, 0);
      chk_state("R4");
    end
    // R5 guarded pops at the top
    for (int i = 0; i < 2; i++) begin
      cycle(0, 1, 0, 0);
      chk_state("R5");
    end

    // R7 drive pointer to zero
    for (int i = 0; i < 62; i++) cycle(1, 0, 0, 0);
    chk("R7 ptr", 64'(ptr), 64'd0);
    chk("R7 mask", mask, 64'd0);
    query_sweep("R7");
    cycle(0, 1, 0, 0);
    chk_state("R4 from zero");
    query_sweep("R8");

    // R10 disable, R3 reads ignored
    cycle(0, 0, 1, 0);
    chk("R10 push_en off", 64'(pe_o), 64'd0);
    cycle(1, 0, 0, 0);
    chk_state("R3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule